// File: doc/BRIEF.md
# SPI Burst Master

This block is a memory-mapped SPI master that runs fixed-length bursts. Software loads command bytes into a transmit queue and sets two counts. The total count says how many bytes the burst clocks. The send count says how many of those bytes come from the transmit queue. Once the send count is used up, the block clocks out 0x00 filler bytes for the rest of the burst. Every byte shifted in is written to a receive queue, including the bytes that arrive while command bytes go out. A host that wants only the payload therefore discards the first send-count bytes it reads back.

A typical memory read loads a one-byte opcode and three address bytes, sets the send count to 4 and the total count to 4 plus the payload length, and sets the go bit. It then polls the go bit until it reads back zero and drains the receive queue. The serial clock is a programmable division of the module clock. A soft-reset bit that clears itself returns the whole block to its reset state.

Register map (byte offsets on a 6-bit address):
- 0x00 control: bit 0 enable, bit 1 master, bit 2 clear-TX, bit 3 clear-RX, bit 4 go/busy, bit 31 soft reset.
- 0x04 clock divider.
- 0x08 total count.
- 0x0C send count.
- 0x10 status.
- 0x20 TX data port (write).
- 0x30 RX data port (read).

Top module: `spi_burst_master`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, and the control and status registers both read 0.
- R2: A burst clocks exactly total-count bytes, MSB first. Bytes 0 to min(send,total)-1 are popped from the TX queue in order, and every later byte is sent as 0x00. When the send count exceeds the total, the unused bytes stay queued.
- R3: Every byte clocked during a burst is pushed to the RX queue, in order. Status bits 6:0 give the RX level (0 to 64) and status bits 14:8 give the TX level.
- R4: Writing control with bit 4 set starts a burst only if the same write also sets bit 0 (enable) and bit 1 (master) and the total count is not zero. Bit 4 reads 1 until the burst ends. In every other case the write does not start a burst and the chip select stays high.
- R5: With divider bit 12 set, the SCK period is 2*(n+1) module clocks, where n is divider bits 7:0. With bit 12 clear, the period is 2^(m+1) clocks, where m is divider bits 11:8.
- R6: Chip select falls one SCK half-period before the first rising SCK edge. It rises on the edge that ends the last bit, and it is never low while the block is idle. SCK idles low, and MOSI is stable while SCK is high (mode 0).
- R7: A TX data write is dropped when the TX queue already holds 64 bytes. A read of the RX port while the RX queue is empty returns 0 and leaves the level at 0.
- R8: A 32-bit read of the RX port pops up to four bytes and returns the oldest byte in bits 7:0, with missing bytes read as 0. A byte read pops one byte into bits 7:0.
- R9: Writing 1 to control bit 2 empties the TX queue, and writing 1 to bit 3 empties the RX queue. Both bits read back as 0.
- R10: Writing 1 to control bit 31 makes that bit read 1 in the next cycle. In the cycle after that, the bit reads 0 and every register, queue and burst has returned to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_valid |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A wrong byte counter shows up as a burst of the wrong length. The RX level is then off by at least one when the go bit clears, and the bytes captured on MOSI miss or gain filler bytes. A stuck bit counter or a wrong shift direction corrupts the first word read back from the RX port, within one burst. A divider fault moves the first SCK edge relative to chip select, and it changes the spacing between the first two rising edges of the very next burst.

// File: rtl/spi_burst_pkg.sv
`timescale 1ns/1ps
package spi_burst_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT} eng_t;

    localparam logic [5:0] A_CTRL  = 6'h00;
    localparam logic [5:0] A_CLK   = 6'h04;
    localparam logic [5:0] A_BURST = 6'h08;
    localparam logic [5:0] A_TXCNT = 6'h0C;
    localparam logic [5:0] A_STAT  = 6'h10;
    localparam logic [5:0] A_TXD   = 6'h20;
    localparam logic [5:0] A_RXD   = 6'h30;

    localparam int B_EN    = 0;
    localparam int B_MST   = 1;
    localparam int B_TXCLR = 2;
    localparam int B_RXCLR = 3;
    localparam int B_GO    = 4;
    localparam int B_SRST  = 31;
endpackage

// File: rtl/spi_burst_fifo.sv
`timescale 1ns/1ps
module spi_burst_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    parameter int PEEK  = 1,
    localparam int AW    = $clog2(DEPTH),
    localparam int LVL_W = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [W-1:0]      din,
    input  logic [2:0]        pop_n,
    output logic [PEEK*W-1:0] peek,
    output logic [LVL_W-1:0]  level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok;

    // a push into a full queue is dropped
    assign push_ok = push && (level < LVL_W'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            rd_ptr <= rd_ptr + AW'(pop_n);
            level  <= level + LVL_W'(push_ok) - LVL_W'(pop_n);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wr_ptr] <= din;
    end

    for (genvar g = 0; g < PEEK; g++) begin : g_peek
        assign peek[g*W +: W] = mem[rd_ptr + AW'(g)];
    end
endmodule

// File: rtl/spi_burst_sckdiv.sv
`timescale 1ns/1ps
module spi_burst_sckdiv (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic [15:0] cfg,
    output logic        tick
);
    // one tick per SCK half-period
    logic [16:0] half, cnt;

    always_comb begin
        if (cfg[12]) half = 17'(cfg[7:0]) + 17'd1;
        else         half = 17'd1 << cfg[11:8];
    end

    assign tick = run && (cnt >= half - 17'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + 17'd1;
    end
endmodule

// File: rtl/spi_burst_master.sv
`timescale 1ns/1ps
module spi_burst_master
    import spi_burst_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int CNT_W      = 16,
    localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic        bus_word,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    typedef struct packed {
        eng_t             fsm;
        logic             cs_n;
        logic             sck;
        logic [7:0]       tx_sh;
        logic [7:0]       rx_sh;
        logic [2:0]       bitcnt;
        logic [CNT_W-1:0] bytes_left;
        logic [CNT_W-1:0] tx_left;
        logic             en;
        logic             master;
        logic             srst;
        logic [15:0]      clkdiv;
        logic [CNT_W-1:0] burst;
        logic [CNT_W-1:0] txcnt;
    } regs_t;

    localparam regs_t RST = '{fsm: ST_IDLE, cs_n: 1'b1, default: '0};

    regs_t q, d;

    logic             tick, busy, wr, rd, start;
    logic             tx_push, tx_pop, tx_clr, rx_push, rx_clr;
    logic [2:0]       rx_pop_n;
    logic [7:0]       tx_peek;
    logic [31:0]      rx_peek;
    logic [LVL_W-1:0] tx_level, rx_level;
    logic [CNT_W-1:0] load_left;
    logic             load_pop;
    logic [7:0]       load_byte;

    spi_burst_fifo #(.DEPTH(FIFO_DEPTH), .W(8), .PEEK(1)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push),
        .din(bus_wdata[7:0]), .pop_n({2'b00, tx_pop}),
        .peek(tx_peek), .level(tx_level));

    spi_burst_fifo #(.DEPTH(FIFO_DEPTH), .W(8), .PEEK(4)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push),
        .din(q.rx_sh), .pop_n(rx_pop_n),
        .peek(rx_peek), .level(rx_level));

    spi_burst_sckdiv u_div (
        .clk(clk), .rst_n(rst_n), .run(q.fsm != ST_IDLE),
        .cfg(q.clkdiv), .tick(tick));

    assign busy     = (q.fsm != ST_IDLE);
    assign spi_sck  = q.sck;
    assign spi_cs_n = q.cs_n;
    assign spi_mosi = q.tx_sh[7];
    assign wr       = bus_valid && bus_write;
    assign rd       = bus_valid && !bus_write;

    // next byte to send: queued data while the send count lasts, then 0x00
    always_comb begin
        load_left = (q.fsm == ST_IDLE) ? q.txcnt : q.tx_left;
        load_pop  = (load_left != '0) && (tx_level != '0);
        load_byte = load_pop ? tx_peek : 8'h00;
    end

    always_comb begin
        d        = q;
        start    = 1'b0;
        tx_push  = 1'b0;
        tx_pop   = 1'b0;
        rx_push  = 1'b0;
        tx_clr   = q.srst;
        rx_clr   = q.srst;
        rx_pop_n = 3'd0;

        if (wr) begin
            case (bus_addr)
                A_CTRL: begin
                    d.en     = bus_wdata[B_EN];
                    d.master = bus_wdata[B_MST];
                    d.srst   = bus_wdata[B_SRST];
                    tx_clr   = tx_clr || bus_wdata[B_TXCLR];
                    rx_clr   = rx_clr || bus_wdata[B_RXCLR];
                    start    = bus_wdata[B_GO] && bus_wdata[B_EN] && bus_wdata[B_MST]
                               && (q.fsm == ST_IDLE) && (q.burst != '0);
                end
                A_CLK:   d.clkdiv = bus_wdata[15:0];
                A_BURST: d.burst  = bus_wdata[CNT_W-1:0];
                A_TXCNT: d.txcnt  = bus_wdata[CNT_W-1:0];
                A_TXD:   tx_push  = 1'b1;
                default: ;
            endcase
        end

        if (rd && bus_addr == A_RXD) begin
            if (!bus_word)                      rx_pop_n = (rx_level != '0) ? 3'd1 : 3'd0;
            else if (rx_level >= LVL_W'(4))     rx_pop_n = 3'd4;
            else                                rx_pop_n = rx_level[2:0];
        end

        if (start) begin
            d.fsm        = ST_LEAD;
            d.cs_n       = 1'b0;
            d.sck        = 1'b0;
            d.bitcnt     = '0;
            d.bytes_left = q.burst;
            d.tx_sh      = load_byte;
            tx_pop       = load_pop;
            d.tx_left    = (load_left != '0) ? load_left - 1'b1 : '0;
        end else if (tick) begin
            case (q.fsm)
                ST_LEAD: begin
                    d.fsm   = ST_SHIFT;
                    d.sck   = 1'b1;
                    d.rx_sh = {q.rx_sh[6:0], spi_miso};
                end
                ST_SHIFT: begin
                    if (!q.sck) begin
                        d.sck   = 1'b1;
                        d.rx_sh = {q.rx_sh[6:0], spi_miso};
                    end else begin
                        d.sck = 1'b0;
                        if (q.bitcnt == 3'd7) begin
                            d.bitcnt     = '0;
                            rx_push      = 1'b1;
                            d.bytes_left = q.bytes_left - 1'b1;
                            if (q.bytes_left == CNT_W'(1)) begin
                                d.fsm  = ST_IDLE;
                                d.cs_n = 1'b1;
                            end else begin
                                d.tx_sh   = load_byte;
                                tx_pop    = load_pop;
                                d.tx_left = (load_left != '0) ? load_left - 1'b1 : '0;
                            end
                        end else begin
                            d.bitcnt = q.bitcnt + 3'd1;
                            d.tx_sh  = {q.tx_sh[6:0], 1'b0};
                        end
                    end
                end
                default: ;
            endcase
        end

        if (q.srst) begin
            d       = RST;
            tx_push = 1'b0;
            tx_pop  = 1'b0;
            rx_push = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = {q.srst, 26'b0, busy, 2'b00, q.master, q.en};
            A_CLK:   bus_rdata = 32'(q.clkdiv);
            A_BURST: bus_rdata = 32'(q.burst);
            A_TXCNT: bus_rdata = 32'(q.txcnt);
            A_STAT: begin
                bus_rdata[LVL_W-1:0]  = rx_level;
                bus_rdata[8 +: LVL_W] = tx_level;
            end
            A_RXD: begin
                for (int i = 0; i < 4; i++) begin
                    if ((bus_word || i == 0) && (rx_level > LVL_W'(i)))
                        bus_rdata[i*8 +: 8] = rx_peek[i*8 +: 8];
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spi_burst_checker.sv
`timescale 1ns/1ps
module spi_burst_checker #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sck,
    input logic             mosi,
    input logic             busy,
    input logic             srst,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] tx_level
);
    a_r6_cs_high_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);
    a_r6_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);
    a_r6_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));
    a_r4_select_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> busy);
    a_r3_rx_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= LVL_W'(DEPTH));
    a_r7_tx_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LVL_W'(DEPTH));
    a_r10_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!busy && rx_level == '0 && tx_level == '0 && !srst));
endmodule

bind spi_burst_master spi_burst_checker #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
    .busy(busy), .srst(q.srst), .rx_level(rx_level), .tx_level(tx_level));

// File: tb/spi_burst_master_tb.sv
`timescale 1ns/1ps
module spi_burst_master_tb;
    import spi_burst_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_word = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

    always #10 clk = ~clk;

    spi_burst_master u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso));

    // ---------------- slave model ----------------
    logic [15:0] sl_idx = '0;
    logic [7:0]  mosi_cap [128];
    logic [7:0]  sl_cur;
    int          rise_n = 0;
    longint      t_cs = 0, t_r1 = 0, t_r2 = 0;

    function automatic logic [7:0] resp(input int k);
        return 8'(k * 29 + 90);
    endfunction

    always @(negedge spi_cs_n) begin
        sl_idx = '0;
        rise_n = 0;
        t_cs   = $time;
    end
    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            mosi_cap[sl_idx[9:3]][3'd7 - sl_idx[2:0]] = spi_mosi;
            if (rise_n == 0) t_r1 = $time;
            if (rise_n == 1) t_r2 = $time;
            rise_n++;
        end
    end
    always @(negedge spi_sck) begin
        if (!spi_cs_n) sl_idx = sl_idx + 16'd1;
    end
    always_comb begin
        sl_cur   = resp(int'(sl_idx[15:3]));
        spi_miso = sl_cur[3'd7 - sl_idx[2:0]];
    end

    // ---------------- checking ----------------
    int nchk = 0, nfail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] dt, input bit word = 1'b1);
        bus_valid = 1'b1; bus_write = 1'b1; bus_word = word; bus_addr = a; bus_wdata = dt;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input bit word, output logic [31:0] dt);
        bus_valid = 1'b1; bus_write = 1'b0; bus_word = word; bus_addr = a;
        #1 dt = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] r;
        r = 32'h10;
        while (r[B_GO]) rd(A_CTRL, 1'b1, r);
        #1;
        chk(spi_cs_n === 1'b1, "R6 cs high after burst", 32'(spi_cs_n), 32'd1);
    endtask

    function automatic int exp_period(input logic [15:0] cd);
        if (cd[12]) return 2 * (int'(cd[7:0]) + 1);
        return 2 << cd[11:8];
    endfunction

    function automatic logic [7:0] txb(input int i);
        return (i == 0) ? 8'h03 : 8'(8'h30 + i);
    endfunction

    // {total[31:24], send[23:16], clkdiv[15:0]}
    localparam int NV = 7;
    localparam logic [31:0] VEC [NV] = '{
        32'h0504_1000, 32'h0C04_1001, 32'h0303_100F, 32'h0800_0000,
        32'h0602_0200, 32'h4004_1000, 32'h0406_1002 };

    initial begin
        #(20 * 150000);
        nfail++;
        $display("FAIL R4 watchdog expired act=timeout exp=finished");
        summary();
    end

    initial begin
        logic [31:0] r;
        logic [31:0] ew;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1 pins after reset", {spi_cs_n, spi_sck}, 32'h2);
        rd(A_CTRL, 1'b1, r); chk(r == 0, "R1 control reset", r, 0);
        rd(A_STAT, 1'b1, r); chk(r == 0, "R1 status reset", r, 0);

        // table-driven bursts: R2 R3 R5 R6 R8
        for (int v = 0; v < NV; v++) begin
            int tot, snd, per, used, bad, nw;
            tot = int'(VEC[v][31:24]); snd = int'(VEC[v][23:16]);
            per = exp_period(VEC[v][15:0]);
            used = (snd < tot) ? snd : tot;
            wr(A_CTRL, 32'h0F);
            wr(A_CLK, 32'(VEC[v][15:0]));
            wr(A_BURST, 32'(tot));
            wr(A_TXCNT, 32'(snd));
            for (int i = 0; i < snd; i++) wr(A_TXD, 32'(txb(i)), 1'b0);
            wr(A_CTRL, 32'h13);
            wait_idle();
            rd(A_STAT, 1'b1, r);
            chk(r[6:0] == 7'(tot), "R3 rx level equals total", 32'(r[6:0]), 32'(tot));
            chk(r[14:8] == 7'(snd - used), "R2 tx leftover", 32'(r[14:8]), 32'(snd - used));
            bad = 0;
            for (int k = 0; k < tot; k++)
                if (mosi_cap[k] !== ((k < used) ? txb(k) : 8'h00)) bad++;
            chk(bad == 0, "R2 mosi bytes", 32'(bad), 0);
            chk((t_r2 - t_r1) == longint'(per * 20), "R5 sck period", 32'((t_r2 - t_r1) / 20), 32'(per));
            chk((t_r1 - t_cs) == longint'(per * 10), "R6 cs lead", 32'((t_r1 - t_cs) / 20), 32'(per / 2));
            bad = 0;
            nw = (tot + 3) / 4;
            for (int w = 0; w < nw; w++) begin
                ew = '0;
                for (int b = 0; b < 4; b++)
                    if (w * 4 + b < tot) ew[b*8 +: 8] = resp(w * 4 + b);
                rd(A_RXD, 1'b1, r);
                if (r !== ew) bad++;
            end
            chk(bad == 0, "R3 R8 rx data words", 32'(bad), 0);
        end

        // R8 byte then word reads, partial word, then R7 empty read
        wr(A_CTRL, 32'h0F); wr(A_CLK, 32'h1000); wr(A_BURST, 6); wr(A_TXCNT, 1);
        wr(A_TXD, 32'hA5, 1'b0);
        wr(A_CTRL, 32'h13);
        wait_idle();
        rd(A_RXD, 1'b0, r); chk(r == 32'(resp(0)), "R8 byte pop", r, 32'(resp(0)));
        rd(A_STAT, 1'b1, r); chk(r[6:0] == 5, "R8 level after byte pop", 32'(r[6:0]), 5);
        rd(A_RXD, 1'b1, r); ew = {resp(4), resp(3), resp(2), resp(1)};
        chk(r == ew, "R8 word little-endian", r, ew);
        rd(A_RXD, 1'b1, r); chk(r == 32'(resp(5)), "R8 partial word", r, 32'(resp(5)));
        rd(A_RXD, 1'b0, r); chk(r == 0, "R7 empty rx read", r, 0);
        rd(A_STAT, 1'b1, r); chk(r[6:0] == 0, "R7 level stays 0", 32'(r[6:0]), 0);

        // R9 rx clear
        wr(A_BURST, 3); wr(A_TXCNT, 0);
        wr(A_CTRL, 32'h13);
        wait_idle();
        wr(A_CTRL, 32'h0B);
        rd(A_STAT, 1'b1, r); chk(r[6:0] == 0, "R9 rx clear", 32'(r[6:0]), 0);
        rd(A_CTRL, 1'b1, r); chk(r[3:2] == 0, "R9 clear bits read 0", r, 32'h3);

        // R7 tx full drop, R9 tx clear
        for (int i = 0; i < 66; i++) wr(A_TXD, 32'(i), 1'b0);
        rd(A_STAT, 1'b1, r); chk(r[14:8] == 64, "R7 tx full drop", 32'(r[14:8]), 64);
        wr(A_CTRL, 32'h07);
        rd(A_STAT, 1'b1, r); chk(r[14:8] == 0, "R9 tx clear", 32'(r[14:8]), 0);

        // R4 go without enable / master, and with zero total
        wr(A_BURST, 2);
        wr(A_CTRL, 32'h10);
        rd(A_CTRL, 1'b1, r); chk(r[B_GO] == 0, "R4 no enable ignored", r, 0);
        wr(A_CTRL, 32'h11);
        repeat (10) @(negedge clk);
        chk(spi_cs_n === 1'b1, "R4 cs stays high without master", 32'(spi_cs_n), 1);
        wr(A_BURST, 0);
        wr(A_CTRL, 32'h13);
        rd(A_CTRL, 1'b1, r); chk(r[B_GO] == 0, "R4 zero total ignored", r, 32'h3);
        rd(A_STAT, 1'b1, r); chk(r == 0, "R4 nothing received", r, 0);

        // R10 soft reset
        wr(A_CLK, 32'h1005); wr(A_BURST, 9);
        wr(A_TXD, 32'h11, 1'b0); wr(A_TXD, 32'h22, 1'b0);
        wr(A_CTRL, 32'h8000_0003);
        rd(A_CTRL, 1'b1, r); chk(r[B_SRST] == 1'b1, "R10 srst reads 1", r, 32'h8000_0003);
        rd(A_CTRL, 1'b1, r); chk(r == 0, "R10 srst self-clears", r, 0);
        rd(A_STAT, 1'b1, r); chk(r == 0, "R10 queues emptied", r, 0);
        rd(A_CLK, 1'b1, r); chk(r == 0, "R10 divider reset", r, 0);
        rd(A_BURST, 1'b1, r); chk(r == 0, "R10 total reset", r, 0);

        summary();
    end
endmodule